// File: doc/BRIEF.md
# Watermarked Multi-Mode Counter

A 4-bit synchronous counter built as an explicit state machine. It counts in plain binary, in reflected Gray code or in decimal (0 to 9), up or down. It has a synchronous clear, a count enable and a terminal-count flag. The control code is 3 bits: the mode in the two upper bits and the direction in the low bit.

A chain of hidden watermark states sits beside the sixteen base states. A secret sequence of control codes, applied from the zero state with enable high, walks the machine through that chain. Each hidden state shows the count value and the terminal flag of the base state it copies. It also leaves on every other input exactly as that base state would, so normal users cannot tell the chain is there. One clock edge after the last hidden state is reached, a watermark flag rises. Its owner can use this flag to prove authorship. The key length is a parameter from 2 to 6 steps, and the key codes are a parameter as well.

Top module: `wm_counter`

## Requirements
- R1: A high `clr_i` at a rising clock edge sets the count to 0 and clears `tc_o` and `wm_o`, whatever the enable and control code are.
- R2: With `clr_i` and `en_i` low, a clock edge leaves the count unchanged and `tc_o` reads 0 after it.
- R3: Mode code 00 (binary) steps the count by +1 when `up_i`=1 and by -1 when `up_i`=0, modulo 16.
- R4: Mode code 01 (Gray) steps along the ring 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8 and back to 0 when `up_i`=1, and the reverse way when `up_i`=0, so down from 0 gives 8.
- R5: Mode code 10 (decimal) wraps 9 to 0 going up and 0 to 9 going down. Any count of 10 to 15 goes to 0, with `tc_o` low.
- R6: Mode code 11 with enable high sends the count to 0 with `tc_o` low.
- R7: After an enabled counting step, `tc_o` is 1 only if the new count is the terminal code for that step. Going up, the terminal code is 15 in binary, 8 in Gray and 9 in decimal. Going down, it is 0 in every mode. Wraps caused by an out-of-range decimal count or by mode 11 never raise it.
- R8: The key codes are 001, 011, 101, 010, 000, 100, the first KEY_LEN of them, applied from count state 0 on consecutive enabled edges. They move the machine into the hidden chain. Throughout, `cnt_o` and `tc_o` stay equal to those of a counter without a watermark.
- R9: `wm_o` rises at the clock edge after the last hidden state has been reached. It stays 1 while that state is held by a low enable, and it falls at the edge after the machine leaves that state.
- R10: An incomplete key, a wrong code in the key or a key not started from 0 never raises `wm_o`. The count behaves exactly as a counter without a watermark.
- R11: A low `rst_ni` clears the count and both flags at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to count 0, highest priority |
| en_i | input | 1 | Count enable; low holds the state |
| mode_i | input | 2 | 00 binary, 01 Gray, 10 decimal, 11 force zero |
| up_i | input | 1 | Direction: 1 up, 0 down |
| cnt_o | output | 4 | Visible count value |
| tc_o | output | 1 | Terminal count reached on the last step |
| wm_o | output | 1 | Watermark chain end reached |

## Verification
The count changes at the edge that samples the control code, and `tc_o` is registered at that same edge, so both are due one edge after the stimulus. The bench drives each code at a falling edge and compares both against its own table-driven model of the counter without a watermark at the next falling edge. `wm_o` lags the entry into the last hidden state by one more edge. The key scenario therefore expects it one apply after the final key code and expects it to drop one apply after the machine leaves. A second instance with a 3-step key runs beside the first, and its flag timing is checked on the same stimulus.

// File: rtl/wm_cnt_pkg.sv
package wm_cnt_pkg;
  localparam int VAL_W   = 4;
  localparam int STATE_W = 5;
  localparam int CODE_W  = 3;
  localparam int MAX_KEY = 6;

  typedef enum logic [1:0] {
    MODE_BIN  = 2'b00,
    MODE_GRAY = 2'b01,
    MODE_BCD  = 2'b10,
    MODE_ZERO = 2'b11
  } mode_e;

  typedef struct packed {
    logic [VAL_W-1:0] val;
    logic             tc;
  } step_t;

  function automatic logic [VAL_W-1:0] gray2bin(input logic [VAL_W-1:0] g);
    logic [VAL_W-1:0] b;
    b[VAL_W-1] = g[VAL_W-1];
    for (int i = VAL_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [VAL_W-1:0] bin2gray(input logic [VAL_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Next visible value of the unwatermarked counter for one enabled edge
  function automatic step_t base_step(input logic [VAL_W-1:0] v,
                                      input logic [CODE_W-1:0] code);
    step_t r;
    logic [VAL_W-1:0] b;
    logic up;
    up = code[0];
    r.val = '0;
    r.tc  = 1'b0;
    case (mode_e'(code[2:1]))
      MODE_BIN: begin
        r.val = up ? VAL_W'(v + 1'b1) : VAL_W'(v - 1'b1);
        r.tc  = up ? (r.val == 4'd15) : (r.val == 4'd0);
      end
      MODE_GRAY: begin
        b     = gray2bin(v);
        b     = up ? VAL_W'(b + 1'b1) : VAL_W'(b - 1'b1);
        r.val = bin2gray(b);
        r.tc  = up ? (r.val == 4'd8) : (r.val == 4'd0);
      end
      MODE_BCD: begin
        if (v > 4'd9) begin
          r.val = '0;
        end else begin
          if (up) r.val = (v == 4'd9) ? 4'd0 : VAL_W'(v + 1'b1);
          else    r.val = (v == 4'd0) ? 4'd9 : VAL_W'(v - 1'b1);
          r.tc = up ? (r.val == 4'd9) : (r.val == 4'd0);
        end
      end
      default: r.val = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wm_cnt_step.sv
module wm_cnt_step
  import wm_cnt_pkg::*;
(
  input  logic [VAL_W-1:0]  val_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [VAL_W-1:0]  nxt_o,
  output logic              tc_o
);
  step_t s;
  assign s     = base_step(val_i, code_i);
  assign nxt_o = s.val;
  assign tc_o  = s.tc;
endmodule

// File: rtl/wm_cnt_chain.sv
module wm_cnt_chain
  import wm_cnt_pkg::*;
#(
  parameter int                          KEY_LEN = 6,
  parameter logic [MAX_KEY*CODE_W-1:0]   KEY     = 18'b001_011_101_010_000_100
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [VAL_W-1:0]   vis_o,
  output logic               adv_o,
  output logic [STATE_W-1:0] adv_state_o
);
  logic [CODE_W-1:0] key_code [KEY_LEN];
  logic [VAL_W-1:0]  copy_val [KEY_LEN];

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_code[g] = KEY[(MAX_KEY-1-g)*CODE_W +: CODE_W];
  end

  // Base value each chain state shadows: the key walked through the plain counter
  always_comb begin
    logic [VAL_W-1:0] v;
    step_t t;
    v = '0;
    for (int i = 0; i < KEY_LEN; i++) begin
      t = base_step(v, key_code[i]);
      v = t.val;
      copy_val[i] = v;
    end
  end

  always_comb begin
    vis_o = state_i[VAL_W-1:0];
    if (state_i[STATE_W-1]) begin
      vis_o = '0;
      for (int i = 0; i < KEY_LEN; i++)
        if (state_i == {2'b10, 3'(i)}) vis_o = copy_val[i];
    end
  end

  always_comb begin
    adv_o       = 1'b0;
    adv_state_o = '0;
    if (state_i == '0 && code_i == key_code[0]) begin
      adv_o       = 1'b1;
      adv_state_o = {2'b10, 3'd0};
    end
    for (int i = 0; i < KEY_LEN - 1; i++) begin
      if (state_i == {2'b10, 3'(i)} && code_i == key_code[i+1]) begin
        adv_o       = 1'b1;
        adv_state_o = {2'b10, 3'(i + 1)};
      end
    end
  end
endmodule

// File: rtl/wm_counter.sv
module wm_counter
  import wm_cnt_pkg::*;
#(
  parameter int                        KEY_LEN = 6,
  parameter logic [MAX_KEY*CODE_W-1:0] KEY     = 18'b001_011_101_010_000_100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             up_i,
  output logic [VAL_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             wm_o
);
  localparam logic [STATE_W-1:0] LAST_ST = {2'b10, 3'(KEY_LEN - 1)};

  logic [STATE_W-1:0] state_q, adv_state;
  logic [CODE_W-1:0]  code;
  logic [VAL_W-1:0]   vis, nxt;
  logic               adv, step_tc, tc_q, wm_q;

  assign code = {mode_i, up_i};

  wm_cnt_chain #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_chain (
    .state_i     (state_q),
    .code_i      (code),
    .vis_o       (vis),
    .adv_o       (adv),
    .adv_state_o (adv_state)
  );

  wm_cnt_step u_step (
    .val_i  (vis),
    .code_i (code),
    .nxt_o  (nxt),
    .tc_o   (step_tc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      tc_q    <= 1'b0;
      wm_q    <= 1'b0;
    end else if (clr_i) begin
      state_q <= '0;
      tc_q    <= 1'b0;
      wm_q    <= 1'b0;
    end else begin
      wm_q <= (state_q == LAST_ST);
      if (en_i) begin
        state_q <= adv ? adv_state : {1'b0, nxt};
        tc_q    <= step_tc;
      end else begin
        tc_q <= 1'b0;
      end
    end
  end

  assign cnt_o = vis;
  assign tc_o  = tc_q;
  assign wm_o  = wm_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0 && !tc_o && !wm_o)); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> ($stable(cnt_o) && !tc_o)); // R2
  AST_BCD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && mode_i == MODE_BCD) |=> (cnt_o <= 4'd9)); // R5
  AST_ZERO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && mode_i == MODE_ZERO) |=> (cnt_o == '0 && !tc_o)); // R6
  AST_TC_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (cnt_o == 4'd0 || cnt_o == 4'd8 || cnt_o == 4'd9 || cnt_o == 4'd15)); // R7
  AST_CHAIN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[STATE_W-1] && state_q != $past(state_q)) |->
      ($past(state_q) == ((state_q[2:0] == 3'd0) ? 5'd0 : 5'(state_q - 5'd1)))); // R8
endmodule

// File: tb/wm_counter_test.sv
module wm_counter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, clr, en, up;
  logic [1:0] mode;
  logic [3:0] cnt, cnt2;
  logic       tc, tc2, wm, wm2;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [3:0] m_val;
  logic       m_tc;
  logic       exp_wm, exp_wm2;
  logic [3:0] ring [16] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd6, 4'd7, 4'd5, 4'd4,
                            4'd12, 4'd13, 4'd15, 4'd14, 4'd10, 4'd11, 4'd9, 4'd8};

  wm_counter #(.KEY_LEN(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .mode_i(mode), .up_i(up),
    .cnt_o(cnt), .tc_o(tc), .wm_o(wm));

  wm_counter #(.KEY_LEN(3)) uut2 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .mode_i(mode), .up_i(up),
    .cnt_o(cnt2), .tc_o(tc2), .wm_o(wm2));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic e, input logic c, input logic [2:0] code);
    int p;
    logic [3:0] n;
    if (c) begin m_val = 0; m_tc = 0; end
    else if (!e) m_tc = 0;
    else begin
      n = 0; m_tc = 0;
      case (code[2:1])
        2'b00: begin
          n = code[0] ? m_val + 4'd1 : m_val - 4'd1;
          m_tc = code[0] ? (n == 15) : (n == 0);
        end
        2'b01: begin
          p = 0;
          for (int i = 0; i < 16; i++) if (ring[i] == m_val) p = i;
          n = code[0] ? ring[(p + 1) % 16] : ring[(p + 15) % 16];
          m_tc = code[0] ? (n == 8) : (n == 0);
        end
        2'b10: begin
          if (m_val > 9) n = 0;
          else begin
            if (code[0]) n = (m_val == 9) ? 4'd0 : m_val + 4'd1;
            else         n = (m_val == 0) ? 4'd9 : m_val - 4'd1;
            m_tc = code[0] ? (n == 9) : (n == 0);
          end
        end
        default: n = 0;
      endcase
      m_val = n;
    end
  endtask

  task automatic apply(input logic e, input logic c, input logic [2:0] code,
                       input string tag);
    en = e; clr = c; mode = code[2:1]; up = code[0];
    @(posedge clk);
    model(e, c, code);
    @(negedge clk);
    check(cnt == m_val, tag, "cnt", cnt, m_val);
    check(tc == m_tc, tag, "tc", tc, m_tc);
    check(wm == exp_wm, tag, "wm", wm, exp_wm);
    check(cnt2 == m_val, tag, "cnt(key3)", cnt2, m_val);
    check(wm2 == exp_wm2, tag, "wm(key3)", wm2, exp_wm2);
  endtask

  task automatic t_reset();
    check(cnt == 0 && !tc && !wm, "R11", "reset outputs", {cnt, tc, wm}, 0);
  endtask

  task automatic t_binary();
    apply(1, 1, 3'b001, "R1");
    for (int i = 0; i < 20; i++) apply(1, 0, 3'b001, "R3 R7");
    for (int i = 0; i < 20; i++) apply(1, 0, 3'b000, "R3 R7");
  endtask

  task automatic t_gray();
    apply(1, 1, 3'b000, "R1");
    for (int i = 0; i < 18; i++) apply(1, 0, 3'b011, "R4 R7");
    for (int i = 0; i < 18; i++) apply(1, 0, 3'b010, "R4 R7");
  endtask

  task automatic t_bcd();
    apply(1, 1, 3'b000, "R1");
    for (int i = 0; i < 12; i++) apply(1, 0, 3'b101, "R5 R7");
    for (int i = 0; i < 12; i++) apply(1, 0, 3'b100, "R5 R7");
    for (int i = 0; i < 12; i++) apply(1, 0, 3'b001, "R3");
    apply(1, 0, 3'b101, "R5");
    for (int i = 0; i < 13; i++) apply(1, 0, 3'b001, "R3");
    apply(1, 0, 3'b100, "R5");
  endtask

  task automatic t_zero_mode();
    for (int i = 0; i < 5; i++) apply(1, 0, 3'b001, "R3");
    apply(1, 0, 3'b111, "R6");
    apply(1, 0, 3'b000, "R3");
    apply(1, 0, 3'b110, "R6");
  endtask

  task automatic t_hold_clear();
    for (int i = 0; i < 6; i++) apply(1, 0, 3'b011, "R4");
    for (int i = 0; i < 4; i++) apply(0, 0, 3'b001, "R2");
    apply(0, 0, 3'b110, "R2");
    apply(1, 1, 3'b001, "R1");
    apply(1, 0, 3'b000, "R7");
    apply(0, 0, 3'b000, "R2");
    apply(0, 1, 3'b000, "R1");
  endtask

  task automatic t_key();
    exp_wm = 0; exp_wm2 = 0;
    apply(1, 1, 3'b000, "R1");
    apply(1, 0, 3'b001, "R8");
    apply(1, 0, 3'b011, "R8");
    apply(1, 0, 3'b101, "R8");
    exp_wm2 = 1;
    apply(1, 0, 3'b010, "R9");
    exp_wm2 = 0;
    apply(1, 0, 3'b000, "R9");
    apply(1, 0, 3'b100, "R8");
    exp_wm = 1;
    apply(0, 0, 3'b001, "R9");
    apply(0, 0, 3'b011, "R9");
    apply(1, 0, 3'b001, "R9");
    exp_wm = 0;
    apply(1, 0, 3'b001, "R9");
    // key rerun, cut by clear in the middle
    apply(1, 1, 3'b000, "R1");
    apply(1, 0, 3'b001, "R8");
    apply(1, 0, 3'b011, "R8");
    apply(1, 1, 3'b101, "R1");
    apply(1, 0, 3'b010, "R10");
    apply(1, 0, 3'b000, "R10");
  endtask

  task automatic t_bad_key();
    exp_wm = 0; exp_wm2 = 0;
    apply(1, 1, 3'b000, "R1");
    apply(1, 0, 3'b001, "R10");
    apply(1, 0, 3'b011, "R10");
    apply(1, 0, 3'b000, "R10");
    apply(1, 0, 3'b010, "R10");
    for (int i = 0; i < 3; i++) apply(1, 0, 3'b100, "R10");
    apply(1, 1, 3'b000, "R1");
    apply(1, 0, 3'b011, "R10");
    apply(1, 0, 3'b101, "R10");
    apply(1, 0, 3'b010, "R10");
    apply(1, 0, 3'b000, "R10");
    apply(1, 0, 3'b100, "R10");
    apply(1, 0, 3'b000, "R10");
    // full key started from 1, not 0
    apply(1, 1, 3'b000, "R1");
    apply(1, 0, 3'b001, "R3");
    apply(1, 0, 3'b001, "R10");
    apply(1, 0, 3'b011, "R10");
    apply(1, 0, 3'b101, "R10");
    apply(1, 0, 3'b010, "R10");
    apply(1, 0, 3'b000, "R10");
    apply(1, 0, 3'b100, "R10");
    apply(1, 0, 3'b000, "R10");
  endtask

  task automatic t_async_reset();
    for (int i = 0; i < 3; i++) apply(1, 0, 3'b001, "R3");
    #(CLK_PERIOD/4) rst_n = 0;
    #1;
    check(cnt == 0 && !tc && !wm, "R11", "async clear", {cnt, tc, wm}, 0);
    m_val = 0; m_tc = 0;
    @(negedge clk) rst_n = 1;
    apply(1, 0, 3'b000, "R11");
  endtask

  initial begin
    rst_n = 0; clr = 0; en = 0; mode = 0; up = 0;
    m_val = 0; m_tc = 0; exp_wm = 0; exp_wm2 = 0;
    #(CLK_PERIOD * 2 + CLK_PERIOD / 2);
    t_reset();
    @(negedge clk) rst_n = 1;
    t_binary();
    t_gray();
    t_bcd();
    t_zero_mode();
    t_hold_clear();
    t_key();
    t_bad_key();
    t_async_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule